// File: doc/BRIEF.md
# Channel and Die Select Address Unhash

This block takes a memory address whose channel-select and die-select bits have been scrambled by XOR hashing and restores those bits. Each select bit sits at a fixed base position in the address. It is flipped when the XOR of a set of higher address bits is 1. Each of those higher bits takes part only when the hash granularity it belongs to (4K, 64K, 2M, 1G or 1T) is enabled.

The caller gives the block the address, how many channel-select bits and die-select bits are in use (as log2 of the channel and die counts), and the five hash enables. It returns the corrected address one clock later, with a valid strobe. The channel bits are corrected first. The die bits are then computed from the address that already carries the channel corrections. Range lookup and translation into a system address are left to neighbouring logic.

Top module: `chan_die_unhash`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was sampled high, and low otherwise.
- R2: While no valid input is sampled, `out_addr` keeps its previous value.
- R3: After synchronous reset, `out_valid` is 0 and `out_addr` is all zeros.
- R4: Channel select bit i (i = 0..3) is located at address bit 8+i. Channel select bit 4 is located at address bit 14.
- R5: For channel bit i, the terms are address bit 15+i under 64K, bit 22+i under 2M, bit 29+i under 1G, and both bits 36+i and 43+i under 1T. The two 1T terms cancel when both are set.
- R6: Address bit 12+i is an extra 4K term for channel bits 0, 1 and 2 only. Channel bits 3 and 4 have no 4K term.
- R7: Die select bit i (i = 0..1) is located at address bit 12+i. Its terms are bit 20+i under 64K, 27+i under 2M, 34+i under 1G and 41+i under 1T. It has no 4K term.
- R8: Only the lowest `ch_log2` channel bits and the lowest `die_log2` die bits are corrected. A `ch_log2` above 5 acts as 5, and a `die_log2` of 3 acts as 2. With both counts zero, the address is returned unchanged.
- R9: `hash_en` bit 0 enables 4K, bit 1 enables 64K, bit 2 enables 2M, bit 3 enables 1G and bit 4 enables 1T. With all enables clear, the address is returned unchanged.
- R10: Address bits outside positions 8 to 14 are passed through unchanged.
- R11: A base bit is inverted exactly when the XOR of its enabled terms is 1. This holds for any mix of enables and counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input address is valid this cycle |
| in_addr | input | 48 | Hashed address |
| ch_log2 | input | 3 | log2 of channel count (0..5, larger acts as 5) |
| die_log2 | input | 2 | log2 of die count (0..2, 3 acts as 2) |
| hash_en | input | 5 | Hash enables: [0]4K [1]64K [2]2M [3]1G [4]1T |
| out_valid | output | 1 | Corrected address is valid |
| out_addr | output | 48 | Corrected address |

## Verification
The bench builds the block with its default parameters: a 48-bit address, five channel-select bits and two die-select bits. These defaults reach the highest term used, bit 47 (the second 1T term of channel bit 4). They also reach the jump of the fifth channel bit to position 14 and both count clamps. Directed single-bit cases show which term moves which base bit and where the 4K term stops. Random addresses with random enables and counts are compared against a reference model of the XOR equations, which covers mixed terms and cancellation.

// File: rtl/unhash_pkg.sv
// Package: shared positions and helpers for the channel/die unhash block.
// Assumes an address of at least 48 bits so every term position exists.
package unhash_pkg;

    // Enable vector positions
    localparam int EN_4K  = 0;
    localparam int EN_64K = 1;
    localparam int EN_2M  = 2;
    localparam int EN_1G  = 3;
    localparam int EN_1T  = 4;
    localparam int EN_W   = 5;

    // Channel term offsets (added to the channel index)
    localparam int CH_OFS_4K   = 12;
    localparam int CH_OFS_64K  = 15;
    localparam int CH_OFS_2M   = 22;
    localparam int CH_OFS_1G   = 29;
    localparam int CH_OFS_1TA  = 36;
    localparam int CH_OFS_1TB  = 43;
    localparam int CH_4K_LIMIT = 3;   // only indices below this see a 4K term
    localparam int CH_BASE_LO  = 8;
    localparam int CH_JUMP_IDX = 4;
    localparam int CH_JUMP_POS = 14;

    // Die term offsets
    localparam int DIE_BASE_LO = 12;
    localparam int DIE_OFS_64K = 20;
    localparam int DIE_OFS_2M  = 27;
    localparam int DIE_OFS_1G  = 34;
    localparam int DIE_OFS_1T  = 41;

    // Base position of channel select bit idx
    function automatic int chan_base(input int idx);
        return (idx == CH_JUMP_IDX) ? CH_JUMP_POS : CH_BASE_LO + idx;
    endfunction

    // Base position of die select bit idx
    function automatic int die_base(input int idx);
        return DIE_BASE_LO + idx;
    endfunction

endpackage

// File: rtl/unhash_chan_stage.sv
// Module: unhash_chan_stage
// Corrects the channel select bits of an address. Purely combinational.
// Assumes cnt has already been clamped to at most NCH, and that every
// term reads the incoming address (no channel term lands on a channel base
// bit that an earlier index could already have changed).
module unhash_chan_stage
    import unhash_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int NCH    = 5,
    localparam int CNT_W = $clog2(NCH + 1)
) (
    input  logic [ADDR_W-1:0] a_in,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [EN_W-1:0]   en,
    output logic [ADDR_W-1:0] a_out
);

    logic [NCH-1:0] flip;

    // One flip decision per channel select bit
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam logic [CNT_W-1:0] IDX = CNT_W'(i);
        logic t_main;
        logic t_4k;

        assign t_main = (en[EN_64K] & a_in[CH_OFS_64K + i])
                      ^ (en[EN_2M]  & a_in[CH_OFS_2M + i])
                      ^ (en[EN_1G]  & a_in[CH_OFS_1G + i])
                      ^ (en[EN_1T]  & (a_in[CH_OFS_1TA + i] ^ a_in[CH_OFS_1TB + i]));

        if (i < CH_4K_LIMIT) begin : g_4k
            assign t_4k = en[EN_4K] & a_in[CH_OFS_4K + i];
        end else begin : g_no4k
            assign t_4k = 1'b0;
        end

        assign flip[i] = (IDX < cnt) & (t_main ^ t_4k);
    end

    // Apply each flip at its base position
    always_comb begin
        a_out = a_in;
        for (int j = 0; j < NCH; j++) begin
            a_out[chan_base(j)] = a_out[chan_base(j)] ^ flip[j];
        end
    end

endmodule

// File: rtl/unhash_die_stage.sv
// Module: unhash_die_stage
// Corrects the die select bits of an address that already carries the
// channel corrections. Purely combinational. Assumes cnt <= NDIE.
module unhash_die_stage
    import unhash_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int NDIE   = 2,
    localparam int CNT_W = $clog2(NDIE + 1)
) (
    input  logic [ADDR_W-1:0] a_in,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [EN_W-2:0]   en_hi,   // enables without 4K: [0]64K..[3]1T
    output logic [ADDR_W-1:0] a_out
);

    logic [NDIE-1:0] flip;

    // One flip decision per die select bit
    for (genvar i = 0; i < NDIE; i++) begin : g_die
        localparam logic [CNT_W-1:0] IDX = CNT_W'(i);
        assign flip[i] = (IDX < cnt) &
                         ((en_hi[EN_64K-1] & a_in[DIE_OFS_64K + i])
                        ^ (en_hi[EN_2M-1]  & a_in[DIE_OFS_2M + i])
                        ^ (en_hi[EN_1G-1]  & a_in[DIE_OFS_1G + i])
                        ^ (en_hi[EN_1T-1]  & a_in[DIE_OFS_1T + i]));
    end

    // Apply each flip at its base position
    always_comb begin
        a_out = a_in;
        for (int j = 0; j < NDIE; j++) begin
            a_out[die_base(j)] = a_out[die_base(j)] ^ flip[j];
        end
    end

endmodule

// File: rtl/chan_die_unhash.sv
// Module: chan_die_unhash
// Top of the unhash block: clamps the bit counts, runs channel then die
// correction, and registers the result with a one-cycle valid strobe.
// Assumes ADDR_W >= 48, NCH <= 5 and NDIE <= 2 (term positions are fixed).
module chan_die_unhash
    import unhash_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int NCH    = 5,
    parameter int NDIE   = 2,
    localparam int CH_CW  = $clog2(NCH + 1),
    localparam int DIE_CW = $clog2(NDIE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [CH_CW-1:0]  ch_log2,
    input  logic [DIE_CW-1:0] die_log2,
    input  logic [EN_W-1:0]   hash_en,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr
);

    localparam logic [CH_CW-1:0]  CH_MAX  = CH_CW'(NCH);
    localparam logic [DIE_CW-1:0] DIE_MAX = DIE_CW'(NDIE);
    localparam logic [ADDR_W-1:0] TOUCH_MASK = ADDR_W'(48'h0000_0000_7F00);

    logic [CH_CW-1:0]  ch_cnt;
    logic [DIE_CW-1:0] die_cnt;
    logic [ADDR_W-1:0] after_ch;
    logic [ADDR_W-1:0] after_die;

    // Clamp requested counts to what the structure supports
    always_comb begin
        ch_cnt  = (ch_log2  > CH_MAX)  ? CH_MAX  : ch_log2;
        die_cnt = (die_log2 > DIE_MAX) ? DIE_MAX : die_log2;
    end

    unhash_chan_stage #(.ADDR_W(ADDR_W), .NCH(NCH)) u_chan (
        .a_in  (in_addr),
        .cnt   (ch_cnt),
        .en    (hash_en),
        .a_out (after_ch)
    );

    unhash_die_stage #(.ADDR_W(ADDR_W), .NDIE(NDIE)) u_die (
        .a_in  (after_ch),
        .cnt   (die_cnt),
        .en_hi (hash_en[EN_W-1:1]),
        .a_out (after_die)
    );

    // Output register: capture on valid, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_addr <= after_die;
        end
    end

    // R1: valid strobe follows input valid by exactly one cycle
    assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R2: result holds while no input is accepted
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_addr));

    // R10: only positions 8..14 may ever change
    assert_passthru_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((out_addr & ~TOUCH_MASK) == ($past(in_addr) & ~TOUCH_MASK)));

    // R9: all enables clear returns the address unchanged
    assert_alloff_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && hash_en == '0) |=> (out_addr == $past(in_addr)));

    // R8: zero counts return the address unchanged
    assert_zero_cnt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ch_log2 == '0 && die_log2 == '0) |=> (out_addr == $past(in_addr)));

endmodule

// File: tb/chan_die_unhash_bench.sv
module chan_die_unhash_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [47:0] in_addr = '0;
    logic [2:0]  ch_log2 = '0;
    logic [1:0]  die_log2 = '0;
    logic [4:0]  hash_en = '0;
    logic        out_valid;
    logic [47:0] out_addr;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    chan_die_unhash u_chan_die_unhash (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .ch_log2(ch_log2), .die_log2(die_log2), .hash_en(hash_en),
        .out_valid(out_valid), .out_addr(out_addr)
    );

    function automatic logic [47:0] ref_model(input logic [47:0] a, input int ch,
                                              input int dn, input logic [4:0] e);
        logic [47:0] r = a;
        int nc = (ch > 5) ? 5 : ch;
        int nd = (dn > 2) ? 2 : dn;
        for (int i = 0; i < nc; i++) begin
            logic t;
            int b = (i == 4) ? 14 : 8 + i;
            t = (e[1] & a[15+i]) ^ (e[2] & a[22+i]) ^ (e[3] & a[29+i])
              ^ (e[4] & a[36+i]) ^ (e[4] & a[43+i]);
            if (i < 3) t = t ^ (e[0] & a[12+i]);
            r[b] = r[b] ^ t;
        end
        for (int i = 0; i < nd; i++) begin
            logic t;
            t = (e[1] & r[20+i]) ^ (e[2] & r[27+i]) ^ (e[3] & r[34+i]) ^ (e[4] & r[41+i]);
            r[12+i] = r[12+i] ^ t;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one vector, check the result one cycle later and the idle hold after it
    task automatic run_one(input string req, input logic [47:0] a, input int ch,
                           input int dn, input logic [4:0] e, input logic [47:0] exp);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a;
        ch_log2 = 3'(ch); die_log2 = 2'(dn); hash_en = e;
        @(negedge clk);
        in_valid = 1'b0; in_addr = ~a;
        check({req, " valid"}, {47'd0, out_valid}, 48'd1);
        check(req, out_addr, exp);
        @(negedge clk);
        check("R1 idle valid", {47'd0, out_valid}, 48'd0);
        check("R2 hold", out_addr, exp);
    endtask

    task automatic t_reset();
        check("R3 reset valid", {47'd0, out_valid}, 48'd0);
        check("R3 reset addr", out_addr, 48'd0);
    endtask

    task automatic t_channel_positions();
        logic [47:0] one = 48'd1;
        run_one("R4 ch0 via 64K", one << 15, 1, 0, 5'b00010, (one << 15) | (one << 8));
        run_one("R4 ch3 via 2M", one << 25, 4, 0, 5'b00100, (one << 25) | (one << 11));
        run_one("R4 ch4 jumps to 14", one << 19, 5, 0, 5'b00010, (one << 19) | (one << 14));
        run_one("R5 ch1 via 1G", one << 30, 2, 0, 5'b01000, (one << 30) | (one << 9));
        run_one("R5 ch4 via 1T hi", one << 47, 5, 0, 5'b10000, (one << 47) | (one << 14));
        run_one("R5 1T pair cancels", (one << 36) | (one << 43), 1, 0, 5'b10000,
                (one << 36) | (one << 43));
    endtask

    task automatic t_fourk();
        logic [47:0] one = 48'd1;
        run_one("R6 ch2 4K", one << 14, 3, 0, 5'b00001, (one << 14) | (one << 10));
        run_one("R6 ch3 no 4K", one << 15, 4, 0, 5'b00001, one << 15);
        run_one("R6 ch4 no 4K", one << 16, 5, 0, 5'b00001, one << 16);
    endtask

    task automatic t_die();
        logic [47:0] one = 48'd1;
        run_one("R7 die0 via 64K", one << 20, 0, 1, 5'b00010, (one << 20) | (one << 12));
        run_one("R7 die1 via 1T", one << 42, 0, 2, 5'b10000, (one << 42) | (one << 13));
        run_one("R7 die no 4K", one << 12, 0, 2, 5'b00001, one << 12);
    endtask

    task automatic t_counts();
        logic [47:0] one = 48'd1;
        run_one("R8 ch4 beyond count", one << 19, 4, 0, 5'b00010, one << 19);
        run_one("R8 ch clamp 7", one << 19, 7, 0, 5'b00010, (one << 19) | (one << 14));
        run_one("R8 die1 beyond count", one << 42, 0, 1, 5'b10000, one << 42);
        run_one("R8 die clamp 3", one << 42, 0, 3, 5'b10000, (one << 42) | (one << 13));
        run_one("R8 zero counts", 48'hFFFF_FFFF_FFFF, 0, 0, 5'b11111, 48'hFFFF_FFFF_FFFF);
    endtask

    task automatic t_enables();
        run_one("R9 all off", 48'hA5C3_F00F_1E2D, 5, 2, 5'b00000, 48'hA5C3_F00F_1E2D);
        run_one("R9 2M only", 48'd1 << 22, 1, 0, 5'b00100, (48'd1 << 22) | (48'd1 << 8));
    endtask

    task automatic t_random();
        for (int k = 0; k < 300; k++) begin
            logic [47:0] a = {16'($urandom), $urandom};
            int ch = int'($urandom_range(0, 7));
            int dn = int'($urandom_range(0, 3));
            logic [4:0] e = 5'($urandom);
            logic [47:0] exp = ref_model(a, ch, dn, e);
            run_one("R11 random", a, ch, dn, e, exp);
            check("R10 outer bits", out_addr & ~48'h7F00, a & ~48'h7F00);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_channel_positions();
        t_fourk();
        t_die();
        t_counts();
        t_enables();
        t_random();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule